// File: doc/BRIEF.md
# Video Capture FIFO Reset Sequencer

This block controls recovery of a video input port's buffering path. Software writes 1 to a self-clearing FIFO-reset bit. The block then stops taking pixel data and pulses clear strobes to the input-side and output-side FIFO pointer and fill-count logic. It waits until every memory-bus request still in flight has completed. After that it drops the reset bit on its own and re-arms capture. Capture resumes only at the next programmed run event, which is the start of a line, a field or a frame.

The block also brings the incoming horizontal sync, vertical sync and task indicator to one internal polarity. In separate-sync mode each sync pin has its own polarity setting. In embedded-code mode, blanking flags that already come out of an upstream decoder are passed through unchanged. The normalised blanking signals feed the start-event detector, and they are also offered to the rest of the capture path.

Top module: `vcap_fifo_rst_seq`

## Requirements
- R1: After reset, `rst_bit_rd`, `capture_en`, `in_fifo_clr` and `out_fifo_clr` are all 0. Capture is armed and waits for the first run event.
- R2: At the clock edge that samples `ctl_wr`=1 with `ctl_rst_wdata`=1 while no sequence is running, `rst_bit_rd` becomes 1 and `capture_en` becomes 0. `capture_en` stays 0 while `rst_bit_rd` is 1.
- R3: In the first cycle of a sequence, `in_fifo_clr` and `out_fifo_clr` are both 1, for exactly one cycle.
- R4: The sequence cannot end while the outstanding-request count is non-zero. The count goes up on `bus_req_issue`, goes down on `bus_req_done`, stays unchanged when both are asserted in the same cycle, and never goes below 0.
- R5: The sequence ends on the edge after the cycle in which the count is 0 and the clear cycle has passed. At that edge `rst_bit_rd` returns to 0 with no further write.
- R6: After completion, `capture_en` rises only on a start event. `evt_sel` chooses the event: 2'b00 = rising edge of normalised horizontal blanking; 2'b01 or 2'b11 = rising edge of normalised vertical blanking; 2'b10 = rising edge of normalised vertical blanking while `field_id` is 0.
- R7: A start event in the same cycle as completion is honoured, so `capture_en` is 1 right after the completing edge.
- R8: When `sep_sync`=1, `hblank_n = (hsync_in == hs_pol)` and `vblank_n = (vsync_in == vs_pol)`. A polarity setting of 1 means the pin is high during blanking. When `sep_sync`=0, the outputs follow `emb_hblank` and `emb_vblank`.
- R9: `task_n = task_in ^ task_pol`.
- R10: A write of 1 while a sequence runs is ignored: there is no new clear pulse and the completion time does not change. A write of 0 at any time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_rst_wdata | input | 1 | Value written to the FIFO-reset bit |
| rst_bit_rd | output | 1 | Read-back of the FIFO-reset bit |
| evt_sel | input | 2 | Run event select (line/field/frame) |
| sep_sync | input | 1 | 1 = separate sync pins, 0 = embedded-code flags |
| hsync_in | input | 1 | Horizontal sync pin |
| vsync_in | input | 1 | Vertical sync pin |
| hs_pol | input | 1 | Horizontal sync polarity (1 = high in blanking) |
| vs_pol | input | 1 | Vertical sync polarity (1 = high in blanking) |
| emb_hblank | input | 1 | Horizontal blanking from embedded-code decoder |
| emb_vblank | input | 1 | Vertical blanking from embedded-code decoder |
| field_id | input | 1 | Field indicator, 0 = first field of frame |
| task_in | input | 1 | Incoming task indicator |
| task_pol | input | 1 | Task polarity, 1 = invert |
| bus_req_issue | input | 1 | A memory-bus request was issued |
| bus_req_done | input | 1 | A memory-bus request completed |
| capture_en | output | 1 | Pixel data acceptance enable |
| in_fifo_clr | output | 1 | Clear input FIFO pointers and counts |
| out_fifo_clr | output | 1 | Clear output FIFO pointers and counts |
| hblank_n | output | 1 | Normalised horizontal blanking, active high |
| vblank_n | output | 1 | Normalised vertical blanking, active high |
| task_n | output | 1 | Normalised task indicator |

## Verification
The bench leaves requests outstanding across a reset write and releases them one at a time. A design that finished early, or one off by a cycle, would drop the reset bit while the count is still non-zero. It raises a blanking edge in the very cycle the drain finishes; a design that handled the event only from the armed state would lose a whole line before capture resumed. It writes 1 again in the middle of a drain, which catches a design that restarts the sequence and pulses the FIFO clears a second time. It also offers a vertical edge in the second field under frame selection, which catches a design that treats a field start as a frame start. Every polarity combination is swept to catch an inverted normalisation.

// File: rtl/vcap_rst_pkg.sv
package vcap_rst_pkg;

  typedef enum logic [1:0] {
    SEQ_ARM   = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_CLEAR = 2'd2,
    SEQ_DRAIN = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    EVT_LINE  = 2'b00,
    EVT_FIELD = 2'b01,
    EVT_FRAME = 2'b10,
    EVT_ALT   = 2'b11
  } evt_sel_e;

  localparam int unsigned NUM_SYNC = 2;
  localparam int unsigned SYNC_H   = 0;
  localparam int unsigned SYNC_V   = 1;

endpackage

// File: rtl/vcap_sync_norm.sv
module vcap_sync_norm
  import vcap_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sep_sync,
  input  logic [1:0] pin_sync,
  input  logic [1:0] pin_pol,
  input  logic [1:0] emb_blank,
  input  logic       task_in,
  input  logic       task_pol,
  input  logic       field_id,
  input  logic [1:0] evt_sel,
  output logic [1:0] blank_n,
  output logic       task_n,
  output logic       start_evt
);

  logic [NUM_SYNC-1:0] blank_q;
  logic [NUM_SYNC-1:0] rise;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_chan
    assign blank_n[g] = sep_sync ? (pin_sync[g] == pin_pol[g]) : emb_blank[g];
    assign rise[g]    = blank_n[g] & ~blank_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) blank_q[g] <= 1'b1;
      else        blank_q[g] <= blank_n[g];
    end
  end

  assign task_n = task_in ^ task_pol;

  always_comb begin
    unique case (evt_sel_e'(evt_sel))
      EVT_LINE:  start_evt = rise[SYNC_H];
      EVT_FRAME: start_evt = rise[SYNC_V] & ~field_id;
      default:   start_evt = rise[SYNC_V];
    endcase
  end

endmodule

// File: rtl/vcap_req_tracker.sv
module vcap_req_tracker #(
  parameter int unsigned CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic done,
  output logic drained
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = issue ^ done;

  always_comb begin
    cnt_d = cnt_q;
    if (issue && !done && cnt_q != CNT_MAX)   cnt_d = cnt_q + 1'b1;
    else if (done && !issue && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign drained = (cnt_q == '0);

endmodule

// File: rtl/vcap_rst_fsm.sv
module vcap_rst_fsm
  import vcap_rst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_rst_wdata,
  input  logic drained,
  input  logic start_evt,
  output logic rst_bit,
  output logic capture_en,
  output logic fifo_clr
);

  seq_state_e state_q, state_d;
  logic       busy;
  logic       req;

  assign busy = (state_q == SEQ_CLEAR) || (state_q == SEQ_DRAIN);
  assign req  = ctl_wr && ctl_rst_wdata && !busy;

  always_comb begin
    state_d = state_q;
    if (req) begin
      state_d = SEQ_CLEAR;
    end else begin
      unique case (state_q)
        SEQ_ARM:   if (start_evt) state_d = SEQ_RUN;
        SEQ_RUN:   state_d = SEQ_RUN;
        SEQ_CLEAR: state_d = SEQ_DRAIN;
        SEQ_DRAIN: if (drained) state_d = start_evt ? SEQ_RUN : SEQ_ARM;
        default:   state_d = SEQ_ARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_ARM;
    else        state_q <= state_d;
  end

  assign rst_bit    = busy;
  assign capture_en = (state_q == SEQ_RUN);
  assign fifo_clr   = (state_q == SEQ_CLEAR);

endmodule

// File: rtl/vcap_fifo_rst_seq.sv
module vcap_fifo_rst_seq
  import vcap_rst_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       ctl_rst_wdata,
  output logic       rst_bit_rd,
  input  logic [1:0] evt_sel,
  input  logic       sep_sync,
  input  logic       hsync_in,
  input  logic       vsync_in,
  input  logic       hs_pol,
  input  logic       vs_pol,
  input  logic       emb_hblank,
  input  logic       emb_vblank,
  input  logic       field_id,
  input  logic       task_in,
  input  logic       task_pol,
  input  logic       bus_req_issue,
  input  logic       bus_req_done,
  output logic       capture_en,
  output logic       in_fifo_clr,
  output logic       out_fifo_clr,
  output logic       hblank_n,
  output logic       vblank_n,
  output logic       task_n
);

  logic [NUM_SYNC-1:0] blank_w;
  logic                start_evt_w;
  logic                drained_w;
  logic                clr_w;

  vcap_sync_norm u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sep_sync  (sep_sync),
    .pin_sync  ({vsync_in, hsync_in}),
    .pin_pol   ({vs_pol, hs_pol}),
    .emb_blank ({emb_vblank, emb_hblank}),
    .task_in   (task_in),
    .task_pol  (task_pol),
    .field_id  (field_id),
    .evt_sel   (evt_sel),
    .blank_n   (blank_w),
    .task_n    (task_n),
    .start_evt (start_evt_w)
  );

  vcap_req_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (bus_req_issue),
    .done    (bus_req_done),
    .drained (drained_w)
  );

  vcap_rst_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_wr        (ctl_wr),
    .ctl_rst_wdata (ctl_rst_wdata),
    .drained       (drained_w),
    .start_evt     (start_evt_w),
    .rst_bit       (rst_bit_rd),
    .capture_en    (capture_en),
    .fifo_clr      (clr_w)
  );

  assign in_fifo_clr  = clr_w;
  assign out_fifo_clr = clr_w;
  assign hblank_n     = blank_w[SYNC_H];
  assign vblank_n     = blank_w[SYNC_V];

endmodule

// File: rtl/vcap_fifo_rst_seq_chk.sv
module vcap_fifo_rst_seq_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ctl_wr,
  input logic ctl_rst_wdata,
  input logic rst_bit_rd,
  input logic bus_req_issue,
  input logic bus_req_done,
  input logic capture_en,
  input logic in_fifo_clr,
  input logic out_fifo_clr,
  input logic start_evt
);

  logic [CNT_W:0] mdl_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdl_cnt <= '0;
    else if (bus_req_issue && !bus_req_done) mdl_cnt <= mdl_cnt + 1'b1;
    else if (bus_req_done && !bus_req_issue && mdl_cnt != '0) mdl_cnt <= mdl_cnt - 1'b1;
  end

  a_r2_halt_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit_rd |-> !capture_en);

  a_r3_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_rst_wdata && !rst_bit_rd) |=> (in_fifo_clr && out_fifo_clr));

  a_r3_clear_only_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    in_fifo_clr |-> rst_bit_rd);

  a_r4_no_early_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_bit_rd && !in_fifo_clr && mdl_cnt != '0) |=> rst_bit_rd);

  a_r6_resume_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_en) |-> $past(start_evt));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit_rd |=> !in_fifo_clr);

endmodule

bind vcap_fifo_rst_seq vcap_fifo_rst_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_wr        (ctl_wr),
  .ctl_rst_wdata (ctl_rst_wdata),
  .rst_bit_rd    (rst_bit_rd),
  .bus_req_issue (bus_req_issue),
  .bus_req_done  (bus_req_done),
  .capture_en    (capture_en),
  .in_fifo_clr   (in_fifo_clr),
  .out_fifo_clr  (out_fifo_clr),
  .start_evt     (start_evt_w)
);

// File: tb/vcap_fifo_rst_seq_bench.sv
`timescale 1ns/1ps
module vcap_fifo_rst_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr, ctl_rst_wdata;
  logic       rst_bit_rd;
  logic [1:0] evt_sel;
  logic       sep_sync, hsync_in, vsync_in, hs_pol, vs_pol;
  logic       emb_hblank, emb_vblank, field_id, task_in, task_pol;
  logic       bus_req_issue, bus_req_done;
  logic       capture_en, in_fifo_clr, out_fifo_clr, hblank_n, vblank_n, task_n;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  vcap_fifo_rst_seq u_vcap_fifo_rst_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rst_wdata(ctl_rst_wdata),
    .rst_bit_rd(rst_bit_rd), .evt_sel(evt_sel), .sep_sync(sep_sync),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .hs_pol(hs_pol), .vs_pol(vs_pol),
    .emb_hblank(emb_hblank), .emb_vblank(emb_vblank), .field_id(field_id),
    .task_in(task_in), .task_pol(task_pol), .bus_req_issue(bus_req_issue),
    .bus_req_done(bus_req_done), .capture_en(capture_en), .in_fifo_clr(in_fifo_clr),
    .out_fifo_clr(out_fifo_clr), .hblank_n(hblank_n), .vblank_n(vblank_n), .task_n(task_n)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // advance one clock; inputs change and outputs are sampled at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // blanking off in separate-sync mode with active-high polarity
  task automatic idle_inputs();
    ctl_wr = 0; ctl_rst_wdata = 0; bus_req_issue = 0; bus_req_done = 0;
    hsync_in = 0; vsync_in = 0; emb_hblank = 0; emb_vblank = 0; field_id = 0;
  endtask

  task automatic line_edge();
    hsync_in = 1; step(); hsync_in = 0; step();
  endtask

  task automatic write_rst(input logic v);
    ctl_wr = 1; ctl_rst_wdata = v; step(); ctl_wr = 0; ctl_rst_wdata = 0;
  endtask

  task automatic t_reset();
    chk("R1", "rst_bit", rst_bit_rd, 1'b0);
    chk("R1", "capture", capture_en, 1'b0);
    chk("R1", "in_clr", in_fifo_clr, 1'b0);
    chk("R1", "out_clr", out_fifo_clr, 1'b0);
    line_edge();
    chk("R6", "capture after first line event", capture_en, 1'b1);
  endtask

  task automatic t_polarity();
    for (int i = 0; i < 8; i++) begin
      sep_sync = 1; hs_pol = i[0]; vs_pol = i[1]; hsync_in = i[2]; vsync_in = ~i[2];
      #1;
      chk("R8", "hblank sep", hblank_n, (i[2] == i[0]));
      chk("R8", "vblank sep", vblank_n, (~i[2] == i[1]));
    end
    sep_sync = 0; emb_hblank = 1; emb_vblank = 0; hsync_in = 0; hs_pol = 1; vs_pol = 0; vsync_in = 0;
    #1;
    chk("R8", "hblank emb", hblank_n, 1'b1);
    chk("R8", "vblank emb", vblank_n, 1'b0);
    for (int i = 0; i < 4; i++) begin
      task_in = i[0]; task_pol = i[1]; #1;
      chk("R9", "task", task_n, i[0] ^ i[1]);
    end
    sep_sync = 1; hs_pol = 1; vs_pol = 1; emb_hblank = 0; task_pol = 0;
    idle_inputs();
    step(); step();
  endtask

  task automatic t_basic();
    write_rst(1'b0);
    chk("R10", "write 0 keeps bit", rst_bit_rd, 1'b0);
    chk("R10", "write 0 keeps capture", capture_en, 1'b1);
    write_rst(1'b1);
    chk("R2", "bit set", rst_bit_rd, 1'b1);
    chk("R2", "capture halted", capture_en, 1'b0);
    chk("R3", "in clear", in_fifo_clr, 1'b1);
    chk("R3", "out clear", out_fifo_clr, 1'b1);
    step();
    chk("R3", "clear one cycle", in_fifo_clr, 1'b0);
    chk("R5", "still busy in drain", rst_bit_rd, 1'b1);
    step();
    chk("R5", "self-cleared", rst_bit_rd, 1'b0);
    chk("R6", "waits for event", capture_en, 1'b0);
    step(); step();
    chk("R6", "still waiting", capture_en, 1'b0);
    vsync_in = 1; step(); vsync_in = 0; step();
    chk("R6", "vertical edge ignored in line mode", capture_en, 1'b0);
    line_edge();
    chk("R6", "resumed on line", capture_en, 1'b1);
  endtask

  task automatic t_drain();
    bus_req_issue = 1; step(); step(); step(); bus_req_issue = 0;
    // count 3
    write_rst(1'b1);
    step();
    bus_req_issue = 1; bus_req_done = 1; step(); // unchanged: 3
    bus_req_issue = 0; step(); step();           // 2 then 1
    chk("R4", "busy with one pending", rst_bit_rd, 1'b1);
    bus_req_done = 0; step();
    chk("R4", "held with one pending", rst_bit_rd, 1'b1);
    write_rst(1'b1);
    chk("R10", "no second clear", in_fifo_clr, 1'b0);
    chk("R10", "still busy", rst_bit_rd, 1'b1);
    bus_req_done = 1; step(); bus_req_done = 0; // count 0 now
    chk("R5", "busy at zero edge", rst_bit_rd, 1'b1);
    step();
    chk("R5", "done after drain", rst_bit_rd, 1'b0);
    chk("R4", "extra done no underflow prep", capture_en, 1'b0);
    bus_req_done = 1; step(); bus_req_done = 0;
    line_edge();
    chk("R6", "resume after drain", capture_en, 1'b1);
  endtask

  task automatic t_same_cycle();
    bus_req_issue = 1; step(); bus_req_issue = 0;
    write_rst(1'b1); // clear
    step();          // drain, count 1
    bus_req_done = 1; step(); bus_req_done = 0; // count 0 now, complete next edge
    hsync_in = 1; step();
    chk("R7", "event at completion honoured", capture_en, 1'b1);
    chk("R7", "bit cleared", rst_bit_rd, 1'b0);
    hsync_in = 0; step();
    // underflow guard: count stayed 0 after the stray done earlier
    chk("R4", "no underflow", rst_bit_rd, 1'b0);
  endtask

  task automatic t_frame();
    evt_sel = 2'b10;
    write_rst(1'b1); step(); step();
    chk("R5", "frame test idle", rst_bit_rd, 1'b0);
    field_id = 1; vsync_in = 1; step(); vsync_in = 0; step();
    chk("R6", "second field not frame start", capture_en, 1'b0);
    field_id = 0; vsync_in = 1; step(); vsync_in = 0; step();
    chk("R6", "frame start resumes", capture_en, 1'b1);
    evt_sel = 2'b01;
    write_rst(1'b1); step(); step();
    field_id = 1; vsync_in = 1; step(); vsync_in = 0; step();
    chk("R6", "field start resumes", capture_en, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt_sel = 2'b00; sep_sync = 1; hs_pol = 1; vs_pol = 1;
    task_in = 0; task_pol = 0;
    idle_inputs();
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_polarity();
    t_basic();
    t_drain();
    t_same_cycle();
    t_frame();
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule